// File: doc/BRIEF.md
# Radio configuration write sequencer

This block brings an RF transceiver into a chosen modem mode by issuing a fixed list of fourteen 32-bit register writes through a serial register port. The port is a separate shifter: the sequencer presents a word with a one-cycle request, and the port holds a busy flag while it shifts the word out. The per-mode words (oscillator, clock, demodulator, the two filter calibration words, the receive frequency word, the AFC word, the slicer word and the modulation base) arrive precomputed on input buses. These buses must stay stable from start to done. The sequencer adds the fixed words itself. It builds the modulation word from its base, the power level and constant fields.

A start pulse begins a run. If a chip reset is requested with the start, the chip-enable output goes low for a set time and then stays high for the same time before the first write. After the coarse calibration word, the sequencer waits a fixed time so that the IF filter calibration can settle before the frequency word is sent. A flag sampled at start selects the second-radio variant, in which only the low six power bits are used. A single done pulse closes the run.

Top module: `radio_cfg_seq`

## Requirements
- R1: After synchronous reset, wr_req_o, busy_o and done_o are low and chip_en_o is high.
- R2: A run writes exactly 14 words, in this order: oscillator, clock, demodulator, fine calibration, coarse calibration, receive frequency, modulation, 0x0000000E, 0x000231E9, AFC, 0x0000003B, 0x0000010C, slicer, 0x000E000F.
- R3: wr_req_o lasts one cycle and is raised only while wr_busy_i is low. The port raises busy on the next edge. Except after the coarse calibration word, the next request follows in the cycle after the first cycle in which busy is seen low, which is one idle sampled cycle.
- R4: Between the end of the coarse calibration write (busy low) and the request for the receive frequency word there are exactly CAL_CYC+1 idle sampled cycles.
- R5: A start with reset_req_i high drives chip_en_o low for exactly RST_CYC cycles from the cycle after start. It then keeps chip_en_o high for RST_CYC cycles with no request, and only then makes the first request. A start without reset_req_i leaves chip_en_o high.
- R6: With second_radio_i low at start, the modulation word is mod_base_i OR 0x2 (bits 3:0) OR (power_i << 13) OR (0x31 << 7), using all 8 power bits.
- R7: With second_radio_i high at start, the power term is (power_i & 0x3F) << 13.
- R8: done_o is high for exactly one cycle per run, after the last write completes. busy_o is low in the following cycle.
- R9: A start pulse while busy_o is high is ignored. It adds no write and no chip_en_o low time, it does not change the power width chosen at the first start, and it causes no extra done pulse.
- R10: busy_o rises only in the cycle after an accepted start, and stays high until the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a configuration run (ignored while busy) |
| reset_req_i | input | 1 | Pulse chip-enable before the writes of this run |
| second_radio_i | input | 1 | Second-radio variant: mask power to 6 bits |
| osc_word_i | input | 32 | Oscillator register word |
| clk_word_i | input | 32 | Clock divider register word |
| demod_word_i | input | 32 | Demodulator register word |
| fine_cal_word_i | input | 32 | Fine IF calibration word |
| coarse_cal_word_i | input | 32 | Coarse IF calibration word |
| rx_freq_word_i | input | 32 | Receive frequency word |
| mod_base_i | input | 32 | Modulation word base (mode, deviation, inversion) |
| power_i | input | 8 | Transmit power level |
| afc_word_i | input | 32 | AFC register word |
| slicer_word_i | input | 32 | Slicer threshold word |
| wr_busy_i | input | 1 | Serial port busy shifting a word |
| wr_req_o | output | 1 | One-cycle write request to the serial port |
| wr_data_o | output | 32 | Word to write, valid with wr_req_o |
| chip_en_o | output | 1 | Transceiver chip enable |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest case to reach is a second start that lands inside a run, especially during the chip-enable low phase, together with a changed second-radio flag. From the ports this can only be seen through the counted chip-enable low time, the number of writes and done pulses, and the power field of the modulation word. The bench sweeps every 8-bit power value under both radio variants, with varying port latency. It sends a reset request on every sixteenth run and a stray start, with the flags flipped, on every third run. It computes each expected word and each idle-gap length arithmetically.

// File: rtl/cfg_seq_pkg.sv
// Package: shared constants and state type for the configuration sequencer.
// Assumes 32-bit register words; write indices follow the fixed order.
package cfg_seq_pkg;
    localparam int WORD_W      = 32;
    localparam int NUM_WRITES  = 14;
    localparam int IDX_W       = $clog2(NUM_WRITES);
    localparam int CAL_IDX     = 4;   // coarse calibration write, followed by wait
    localparam int LAST_IDX    = NUM_WRITES - 1;

    localparam logic [WORD_W-1:0] W_TEST_DAC  = 32'h0000_000E;
    localparam logic [WORD_W-1:0] W_AGC       = 32'h0002_31E9;
    localparam logic [WORD_W-1:0] W_SYNC      = 32'h0000_003B;
    localparam logic [WORD_W-1:0] W_SYNC_TH   = 32'h0000_010C;
    localparam logic [WORD_W-1:0] W_TEST_OFF  = 32'h000E_000F;

    localparam logic [3:0] MOD_ADDR   = 4'b0010;
    localparam logic [5:0] PA_FIELD   = 6'b110001;
    localparam int         PA_LSB     = 7;
    localparam int         PWR_LSB    = 13;
    localparam int         PWR_KEEP   = 6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RST_LO, ST_RST_HI, ST_SEND, ST_DRAIN, ST_CAL, ST_DONE
    } seq_state_t;
endpackage

// File: rtl/cfg_mod_word.sv
// Module: builds the modulation register word from its base and fields.
// Assumes the power field fits below bit 32 from PWR_LSB.
module cfg_mod_word
    import cfg_seq_pkg::*;
#(
    parameter int PWR_W = 8
) (
    input  logic [WORD_W-1:0] base_i,
    input  logic [PWR_W-1:0]  power_i,
    input  logic              narrow_i,
    output logic [WORD_W-1:0] word_o
);
    localparam logic [PWR_W-1:0] KEEP_MASK = PWR_W'((1 << PWR_KEEP) - 1);

    logic [PWR_W-1:0] pwr_eff;

    // Select full or six-bit power and OR all fields onto the base.
    always_comb begin
        pwr_eff = narrow_i ? (power_i & KEEP_MASK) : power_i;
        word_o  = base_i
                | {{(WORD_W-4){1'b0}}, MOD_ADDR}
                | (WORD_W'(PA_FIELD) << PA_LSB)
                | (WORD_W'(pwr_eff) << PWR_LSB);
    end
endmodule

// File: rtl/cfg_word_sel.sv
// Module: maps a write index to the word to send, in the fixed order.
// Assumes the input words are held stable for the whole run.
module cfg_word_sel
    import cfg_seq_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] osc_i,
    input  logic [WORD_W-1:0] clkw_i,
    input  logic [WORD_W-1:0] demod_i,
    input  logic [WORD_W-1:0] fine_i,
    input  logic [WORD_W-1:0] coarse_i,
    input  logic [WORD_W-1:0] rxf_i,
    input  logic [WORD_W-1:0] mod_i,
    input  logic [WORD_W-1:0] afc_i,
    input  logic [WORD_W-1:0] slicer_i,
    output logic [WORD_W-1:0] word_o
);
    // Index decode; fine calibration deliberately precedes coarse.
    always_comb begin
        case (idx_i)
            IDX_W'(0):  word_o = osc_i;
            IDX_W'(1):  word_o = clkw_i;
            IDX_W'(2):  word_o = demod_i;
            IDX_W'(3):  word_o = fine_i;
            IDX_W'(4):  word_o = coarse_i;
            IDX_W'(5):  word_o = rxf_i;
            IDX_W'(6):  word_o = mod_i;
            IDX_W'(7):  word_o = W_TEST_DAC;
            IDX_W'(8):  word_o = W_AGC;
            IDX_W'(9):  word_o = afc_i;
            IDX_W'(10): word_o = W_SYNC;
            IDX_W'(11): word_o = W_SYNC_TH;
            IDX_W'(12): word_o = slicer_i;
            default:    word_o = W_TEST_OFF;
        endcase
    end
endmodule

// File: rtl/cfg_delay.sv
// Module: loadable down-counter used for reset and calibration waits.
// Assumes load values fit CNT_W bits; zero_o flags expiry.
module cfg_delay #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (load_i)           cnt_q <= val_i;
        else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/radio_cfg_seq.sv
// Module: top-level sequencer issuing the transceiver configuration writes.
// Assumes the serial port raises busy on the edge after a request and that
// RST_CYC and CAL_CYC are at least 1.
module radio_cfg_seq
    import cfg_seq_pkg::*;
#(
    parameter int RST_CYC = 20,
    parameter int CAL_CYC = 50,
    parameter int PWR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              reset_req_i,
    input  logic              second_radio_i,
    input  logic [WORD_W-1:0] osc_word_i,
    input  logic [WORD_W-1:0] clk_word_i,
    input  logic [WORD_W-1:0] demod_word_i,
    input  logic [WORD_W-1:0] fine_cal_word_i,
    input  logic [WORD_W-1:0] coarse_cal_word_i,
    input  logic [WORD_W-1:0] rx_freq_word_i,
    input  logic [WORD_W-1:0] mod_base_i,
    input  logic [PWR_W-1:0]  power_i,
    input  logic [WORD_W-1:0] afc_word_i,
    input  logic [WORD_W-1:0] slicer_word_i,
    input  logic              wr_busy_i,
    output logic              wr_req_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              chip_en_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int MAX_CYC = (RST_CYC > CAL_CYC) ? RST_CYC : CAL_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RST_LOAD = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] CAL_LOAD = CNT_W'(CAL_CYC - 1);

    seq_state_t        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic              narrow_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic [WORD_W-1:0] mod_word;

    // Choose when the shared delay counter is loaded, and with what.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = RST_LOAD;
        if (state_q == ST_IDLE && start_i && reset_req_i) begin
            tmr_load = 1'b1;
        end else if (state_q == ST_RST_LO && tmr_zero) begin
            tmr_load = 1'b1;
        end else if (state_q == ST_DRAIN && !wr_busy_i && idx_q == IDX_W'(CAL_IDX)) begin
            tmr_load = 1'b1;
            tmr_val  = CAL_LOAD;
        end
    end

    // Main sequence: reset pulse, writes with handshake, calibration pause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            narrow_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    idx_q    <= '0;
                    narrow_q <= second_radio_i;
                    state_q  <= reset_req_i ? ST_RST_LO : ST_SEND;
                end
                ST_RST_LO: if (tmr_zero) state_q <= ST_RST_HI;
                ST_RST_HI: if (tmr_zero) state_q <= ST_SEND;
                ST_SEND:   state_q <= ST_DRAIN;
                ST_DRAIN: if (!wr_busy_i) begin
                    if (idx_q == IDX_W'(LAST_IDX)) begin
                        state_q <= ST_DONE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= (idx_q == IDX_W'(CAL_IDX)) ? ST_CAL : ST_SEND;
                    end
                end
                ST_CAL:    if (tmr_zero) state_q <= ST_SEND;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    cfg_delay #(.CNT_W(CNT_W)) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    cfg_mod_word #(.PWR_W(PWR_W)) u_mod (
        .base_i   (mod_base_i),
        .power_i  (power_i),
        .narrow_i (narrow_q),
        .word_o   (mod_word)
    );

    cfg_word_sel u_sel (
        .idx_i    (idx_q),
        .osc_i    (osc_word_i),
        .clkw_i   (clk_word_i),
        .demod_i  (demod_word_i),
        .fine_i   (fine_cal_word_i),
        .coarse_i (coarse_cal_word_i),
        .rxf_i    (rx_freq_word_i),
        .mod_i    (mod_word),
        .afc_i    (afc_word_i),
        .slicer_i (slicer_word_i),
        .word_o   (wr_data_o)
    );

    // Outputs decoded directly from the state register.
    assign wr_req_o  = (state_q == ST_SEND);
    assign chip_en_o = (state_q != ST_RST_LO);
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/radio_cfg_seq_chk.sv
// Module: protocol checker bound to the sequencer top.
// Assumes a port that raises busy on the edge after each request.
module radio_cfg_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic wr_busy_i,
    input logic wr_req_o,
    input logic chip_en_o,
    input logic busy_o,
    input logic done_o
);
    // R3: request is a single-cycle pulse.
    p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |=> !wr_req_o);

    // R3: no request while the port is busy.
    p_req_port_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> !wr_busy_i);

    // R8: done lasts one cycle and the block is idle afterwards.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R10: busy rises only after a start.
    p_busy_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R5: chip enable low only inside a run, never while writing.
    p_ce_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en_o |-> (busy_o && !wr_req_o));
endmodule

bind radio_cfg_seq radio_cfg_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .wr_busy_i (wr_busy_i),
    .wr_req_o  (wr_req_o),
    .chip_en_o (chip_en_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/sim_radio_cfg_seq.sv
module sim_radio_cfg_seq;
    localparam int RST_CYC = 20;
    localparam int CAL_CYC = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, reset_req_i = 1'b0, second_radio_i = 1'b0;
    logic [31:0] osc, clkw, demod, fine, coarse, rxf, modb, afc, slicer;
    logic [7:0]  power;
    logic        wr_busy_i = 1'b0;
    logic        wr_req_o, chip_en_o, busy_o, done_o;
    logic [31:0] wr_data_o;

    int checks = 0, errors = 0, cycles = 0;
    int nwr = 0, lo_cnt = 0, hi_cnt = 0, done_cnt = 0, gap = 0, lat_base = 0, port_cnt = 0;
    logic [31:0] cap [16];
    int          gaps [16];

    always #5 clk = ~clk;

    radio_cfg_seq #(.RST_CYC(RST_CYC), .CAL_CYC(CAL_CYC), .PWR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .reset_req_i(reset_req_i),
        .second_radio_i(second_radio_i), .osc_word_i(osc), .clk_word_i(clkw),
        .demod_word_i(demod), .fine_cal_word_i(fine), .coarse_cal_word_i(coarse),
        .rx_freq_word_i(rxf), .mod_base_i(modb), .power_i(power), .afc_word_i(afc),
        .slicer_word_i(slicer), .wr_busy_i(wr_busy_i), .wr_req_o(wr_req_o),
        .wr_data_o(wr_data_o), .chip_en_o(chip_en_o), .busy_o(busy_o), .done_o(done_o));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Serial port model: busy from the edge after a request for lat cycles.
    always @(posedge clk) begin
        if (wr_req_o) begin
            wr_busy_i <= 1'b1;
            port_cnt  <= (lat_base + nwr) % 4 + 1;
        end else if (wr_busy_i) begin
            if (port_cnt == 1) wr_busy_i <= 1'b0;
            port_cnt <= port_cnt - 1;
        end
    end

    // Monitor sampled away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (!chip_en_o) lo_cnt++;
        else if (lo_cnt > 0 && nwr == 0 && !wr_req_o) hi_cnt++;
        if (wr_req_o) begin
            if (nwr < 16) begin
                cap[nwr]  = wr_data_o;
                gaps[nwr] = gap;
            end
            nwr++;
            gap = 0;
        end else if (!wr_busy_i) gap++;
        else gap = 0;
        if (done_o) done_cnt++;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(negedge clk) begin
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 190000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] exp_word(input int i, input bit narrow);
        logic [7:0] pe;
        pe = narrow ? (power & 8'h3F) : power;
        case (i)
            0: return osc;      1: return clkw;   2: return demod;
            3: return fine;     4: return coarse; 5: return rxf;
            6: return modb | 32'h2 | (32'h31 << 7) | ({24'h0, pe} << 13);
            7: return 32'h0000_000E;  8: return 32'h0002_31E9;
            9: return afc;      10: return 32'h0000_003B;
            11: return 32'h0000_010C; 12: return slicer;
            default: return 32'h000E_000F;
        endcase
    endfunction

    task automatic do_run(input int p, input bit narrow, input bit rreq, input bit stray);
        int t;
        osc    = 32'h0100_0011 + p * 32'h0001_0203;
        clkw   = 32'h2000_0003 ^ (p << 8);
        demod  = 32'h0300_0004 + p * 7;
        fine   = 32'h0000_0406 + (p << 12);
        coarse = 32'h0000_5005 ^ (p << 16);
        rxf    = 32'h5A00_0000 + (p << 4);
        modb   = (p[0] ? 32'h8000_0000 : 32'h0000_0000) | (p << 19) | 32'h70;
        afc    = 32'h0C00_000A + p;
        slicer = 32'h0000_000D | (p << 4);
        power  = p[7:0];
        lat_base = p;
        nwr = 0; lo_cnt = 0; hi_cnt = 0; done_cnt = 0; gap = 0;
        reset_req_i = rreq; second_radio_i = narrow; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (stray) begin
            repeat (8) @(negedge clk);
            reset_req_i = 1'b1; second_radio_i = ~narrow; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        t = 0;
        while (done_cnt == 0 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        check(nwr == 14, "R2/R9 write count", nwr, 14);
        for (int i = 0; i < 14; i++)
            check(cap[i] === exp_word(i, narrow), (i == 6) ? (narrow ? "R7 mod word" : "R6 mod word") : "R2 word order", cap[i], exp_word(i, narrow));
        for (int i = 1; i < 14; i++)
            check(gaps[i] == ((i == 5) ? CAL_CYC + 1 : 1), (i == 5) ? "R4 cal gap" : "R3 handshake gap", gaps[i], (i == 5) ? CAL_CYC + 1 : 1);
        check(done_cnt == 1, "R8/R9 done count", done_cnt, 1);
        check(!busy_o, "R8 idle after done", busy_o, 0);
        if (rreq) begin
            check(lo_cnt == RST_CYC, "R5 ce low time", lo_cnt, RST_CYC);
            check(hi_cnt == RST_CYC, "R5 ce high before write", hi_cnt, RST_CYC);
        end else begin
            check(lo_cnt == 0, "R5/R9 ce untouched", lo_cnt, 0);
        end
    endtask

    initial begin
        osc = '0; clkw = '0; demod = '0; fine = '0; coarse = '0; rxf = '0;
        modb = '0; afc = '0; slicer = '0; power = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!wr_req_o && !busy_o && !done_o && chip_en_o, "R1 reset state",
              {28'h0, wr_req_o, busy_o, done_o, chip_en_o}, 32'h1);
        // R10: busy rises the cycle after start
        reset_req_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o, "R10 busy after start", busy_o, 1);
        while (busy_o) @(negedge clk);
        repeat (2) @(negedge clk);
        for (int p = 0; p < 256; p++) begin
            do_run(p, 1'b0, (p % 16) == 0, (p % 3) == 0);
            do_run(p, 1'b1, (p % 16) == 8, (p % 3) == 1);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule